// File: doc/BRIEF.md
# Seven-to-four transmit gearbox

This block sits between pixel-rate logic and an output double-rate gearing stage. Once per pixel period, upstream logic presents one 7-bit word on each of four data lanes together with a word strobe. The block runs on the fabric clock, which is 1.75 times the pixel clock, so seven fabric cycles span four pixel periods. On every fabric cycle it hands each lane's next four serial bits to the output stage as a nibble.

A fifth lane carries the forwarded clock. It passes the constant word 1100011 through the same buffering as the data lanes, so its edges stay in step with the data words. All lanes share one occupancy counter and one word strobe, so the bits of one pixel word leave every lane in the same fabric cycles.

A ready output tells the source whether a word presented now would be stored. An underflow output reports any fabric cycle in which a nibble was due but the buffer held fewer than four bits.

Top module: `tx_gearbox`

## Requirements
- R1: While reset is held, every nibble output is zero, underflow is low and ready is high.
- R2: After reset, nibble outputs stay zero until the buffer has held at least one whole word. Draining starts in the second cycle after that. The first nonzero-capable nibble is presented after the second clock edge following the edge that stores the first word.
- R3: Once draining has started, each fabric cycle presents the next four serial bits of every lane on that lane's nibble. Nibble bit 0 is the earliest bit in time, and bits 0 and 2 are the even (rising) slots. Lane n uses `nib_o[4n+3:4n]`, where lanes 0 to 3 are data and lane 4 is the forwarded clock.
- R4: Each word is sent most significant bit first, from bit 6 down to bit 0. Words leave in the order they were accepted, with no gap at word boundaries. Data lane n takes its word from `px_words[7n+6:7n]`.
- R5: The forwarded-clock lane sends the serial sequence 1,1,0,0,0,1,1 once for every accepted word, aligned with that word's data bits.
- R6: In a draining cycle where fewer than four bits are buffered, the presented nibbles are all zero, underflow is high, and no buffered bit is consumed.
- R7: Ready is high exactly when a word fits in the 28-bit buffer after this cycle's draw. A strobe while ready is low is ignored, and that word never appears on any lane.
- R8: A steady cadence of four strobes per seven fabric cycles is sustained with ready always high and no underflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| word_stb | input | 1 | A word is presented on every data lane this cycle |
| px_words | input | 28 | Four 7-bit lane words, lane n at bits 7n+6..7n |
| ready | output | 1 | A strobe this cycle would be stored |
| nib_o | output | 20 | Five 4-bit nibbles, lane n at bits 4n+3..4n, lane 4 is the clock lane |
| uflow_o | output | 1 | The nibbles presented this cycle were due but not available |

## Verification
The four data lanes carry every 7-bit value, its complement, a multiplied sequence and a rotated XOR pattern at the same time. A lane swap, a reversed bit order or a misplaced word boundary therefore shows up on at least one lane. The nominal four-in-seven cadence checks continuous streaming. A pause in strobes drives the block into underflow and then checks that the stuck bits resume in order. A strobe on every cycle forces ready low, which shows whether dropped words really vanish. A sparser three-in-seven cadence after a mid-run reset gives periodic underflow and checks that reset clears the buffer and the start condition.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  // Width of an occupancy count able to hold values 0..cap
  function automatic int count_width(input int cap);
    int w;
    w = 1;
    while ((1 << w) <= cap) w++;
    return w;
  endfunction
endpackage

// File: rtl/gbx_ctrl.sv
module gbx_ctrl #(
  parameter int WORD_W = 7,
  parameter int NIB_W  = 4,
  parameter int BUF_W  = 28,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_stb,
  output logic             ready,
  output logic             push_ev,
  output logic             pop_ev,
  output logic             uflow_ev,
  output logic             running,
  output logic [CNT_W-1:0] occ,
  output logic [CNT_W-1:0] base,
  output logic             uflow_o
);
  localparam logic [CNT_W-1:0] NIB_C  = CNT_W'(NIB_W);
  localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] ROOM_C = CNT_W'(BUF_W - WORD_W);

  logic [CNT_W-1:0] occ_q, occ_d, after_pop;
  logic             run_q, uf_q;

  // Occupancy left once this cycle's nibble has been drawn
  function automatic logic [CNT_W-1:0] drained(input logic [CNT_W-1:0] o, input logic take);
    return take ? (o - NIB_C) : o;
  endfunction

  always_comb begin
    pop_ev    = run_q && (occ_q >= NIB_C);
    uflow_ev  = run_q && (occ_q < NIB_C);
    after_pop = drained(occ_q, pop_ev);
    ready     = (after_pop <= ROOM_C);
    push_ev   = word_stb && ready;
    occ_d     = after_pop + (push_ev ? WORD_C : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
      run_q <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      occ_q <= occ_d;
      run_q <= run_q | (occ_q >= WORD_C);
      uf_q  <= uflow_ev;
    end
  end

  assign running = run_q;
  assign occ     = occ_q;
  assign base    = after_pop;
  assign uflow_o = uf_q;
endmodule

// File: rtl/gbx_lane.sv
module gbx_lane #(
  parameter int WORD_W = 7,
  parameter int NIB_W  = 4,
  parameter int BUF_W  = 28,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              push_ev,
  input  logic              pop_ev,
  input  logic [CNT_W-1:0]  base_i,
  output logic [NIB_W-1:0]  nib_o
);
  // Index 0 of the buffer is the next bit on the wire
  logic [BUF_W-1:0] buf_q, buf_d, kept, fresh;
  logic [NIB_W-1:0] nib_q;

  // Bit k of the result is the k-th bit in time: word MSB first
  function automatic logic [WORD_W-1:0] serial_order(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int k = 0; k < WORD_W; k++) r[k] = w[WORD_W-1-k];
    return r;
  endfunction

  always_comb begin
    kept  = pop_ev ? (buf_q >> NIB_W) : buf_q;
    fresh = {{(BUF_W-WORD_W){1'b0}}, serial_order(word_i)} << base_i;
    buf_d = push_ev ? (kept | fresh) : kept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      nib_q <= '0;
    end else begin
      buf_q <= buf_d;
      nib_q <= pop_ev ? buf_q[NIB_W-1:0] : '0;
    end
  end

  assign nib_o = nib_q;
endmodule

// File: rtl/tx_gearbox.sv
module tx_gearbox #(
  parameter int                LANES       = 4,
  parameter int                WORD_W      = 7,
  parameter int                NIB_W       = 4,
  parameter logic [WORD_W-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         word_stb,
  input  logic [LANES*WORD_W-1:0]      px_words,
  output logic                         ready,
  output logic [(LANES+1)*NIB_W-1:0]   nib_o,
  output logic                         uflow_o
);
  localparam int BUF_W  = NIB_W * WORD_W;
  localparam int CNT_W  = gbx_pkg::count_width(BUF_W);
  localparam int ALL_LN = LANES + 1;

  logic             push_ev, pop_ev, uflow_ev, running;
  logic [CNT_W-1:0] occ, base;

  gbx_ctrl #(
    .WORD_W(WORD_W), .NIB_W(NIB_W), .BUF_W(BUF_W), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .word_stb(word_stb), .ready(ready),
    .push_ev(push_ev), .pop_ev(pop_ev), .uflow_ev(uflow_ev),
    .running(running), .occ(occ), .base(base), .uflow_o(uflow_o)
  );

  for (genvar g = 0; g < ALL_LN; g++) begin : g_lane
    logic [WORD_W-1:0] lane_word;
    if (g < LANES) begin : g_data
      assign lane_word = px_words[g*WORD_W +: WORD_W];
    end else begin : g_fwd_clk
      assign lane_word = CLK_PATTERN;
    end
    gbx_lane #(
      .WORD_W(WORD_W), .NIB_W(NIB_W), .BUF_W(BUF_W), .CNT_W(CNT_W)
    ) i_lane (
      .clk(clk), .rst(rst), .word_i(lane_word), .push_ev(push_ev),
      .pop_ev(pop_ev), .base_i(base), .nib_o(nib_o[g*NIB_W +: NIB_W])
    );
  end
endmodule

// File: rtl/gbx_checker.sv
module gbx_checker #(
  parameter int WORD_W = 7,
  parameter int NIB_W  = 4,
  parameter int BUF_W  = 28,
  parameter int CNT_W  = 5,
  parameter int OUT_W  = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             push_ev,
  input logic             pop_ev,
  input logic             uflow_ev,
  input logic             running,
  input logic [CNT_W-1:0] occ,
  input logic [OUT_W-1:0] nib_o,
  input logic             uflow_o
);
  localparam logic [CNT_W-1:0] NIB_C  = CNT_W'(NIB_W);
  localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] BUF_C  = CNT_W'(BUF_W);

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !running |=> (nib_o == '0));
  a_r2_run_sticky: assert property (@(posedge clk) disable iff (rst)
    running |=> running);
  a_r6_uflow_quiet: assert property (@(posedge clk) disable iff (rst)
    uflow_o |-> (nib_o == '0));
  a_r6_uflow_cause: assert property (@(posedge clk) disable iff (rst)
    uflow_ev |-> (occ < NIB_C));
  a_r3_drain_step: assert property (@(posedge clk) disable iff (rst)
    (pop_ev && !push_ev) |=> (occ == $past(occ) - NIB_C));
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= BUF_C);
  a_r4_refill: assert property (@(posedge clk) disable iff (rst)
    push_ev |=> (occ >= WORD_C));
endmodule

bind tx_gearbox gbx_checker #(
  .WORD_W(WORD_W), .NIB_W(NIB_W), .BUF_W(BUF_W), .CNT_W(CNT_W),
  .OUT_W((LANES+1)*NIB_W)
) i_chk (
  .clk(clk), .rst(rst), .push_ev(push_ev), .pop_ev(pop_ev),
  .uflow_ev(uflow_ev), .running(running), .occ(occ),
  .nib_o(nib_o), .uflow_o(uflow_o)
);

// File: tb/test_tx_gearbox.sv
module test_tx_gearbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_stb = 1'b0;
  logic [27:0] px_words = '0;
  logic        ready;
  logic [19:0] nib_o;
  logic        uflow_o;

  tx_gearbox i_tx_gearbox (
    .clk(clk), .rst(rst), .word_stb(word_stb), .px_words(px_words),
    .ready(ready), .nib_o(nib_o), .uflow_o(uflow_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [0:4095] lbits [5];
  int wr_i = 0, rd_i = 0;
  bit mrun = 0;
  logic [19:0] exp_nib = '0;
  bit exp_uf = 0;
  int dropped = 0, uf_seen = 0, stall_seen = 0;
  localparam logic [6:0] FWD = 7'b1100011;

  task automatic check(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [27:0] gen(input int i);
    logic [6:0] v, a, b, c, d;
    v = 7'(i);
    a = v;
    b = ~v;
    c = 7'(i * 37 + 5);
    d = {v[0], v[6:1]} ^ 7'h55;
    return {d, c, b, a};
  endfunction

  // One fabric cycle: check last edge's result, then drive and model the next edge
  task automatic step(input bit stb, input logic [27:0] w, input string req);
    int occ;
    bit mpop, muf, mready;
    @(negedge clk);
    for (int l = 0; l < 5; l++)
      check((l == 4) ? "R5" : req, nib_o[l*4 +: 4] === exp_nib[l*4 +: 4],
            $sformatf("lane %0d nibble", l), 32'(nib_o[l*4 +: 4]), 32'(exp_nib[l*4 +: 4]));
    check("R6", uflow_o === exp_uf, "underflow", 32'(uflow_o), 32'(exp_uf));
    if (exp_uf) uf_seen++;
    occ    = wr_i - rd_i;
    mpop   = mrun && occ >= 4;
    muf    = mrun && occ < 4;
    mready = (occ - (mpop ? 4 : 0) + 7) <= 28;
    check("R7", ready === mready, "ready", 32'(ready), 32'(mready));
    if (!mready) stall_seen++;
    if (stb && !mready) dropped++;
    word_stb = stb;
    px_words = w;
    exp_nib = '0;
    if (mpop) begin
      for (int l = 0; l < 5; l++)
        for (int i = 0; i < 4; i++) exp_nib[l*4+i] = lbits[l][rd_i+i];
      rd_i += 4;
    end
    exp_uf = muf;
    if (occ >= 7) mrun = 1;
    if (stb && mready) begin
      for (int k = 0; k < 7; k++) begin
        for (int l = 0; l < 4; l++) lbits[l][wr_i+k] = w[l*7 + 6 - k];
        lbits[4][wr_i+k] = FWD[6-k];
      end
      wr_i += 7;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    word_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", nib_o === '0, "nibbles in reset", 32'(nib_o), 0);
    check("R1", uflow_o === 1'b0, "underflow in reset", 32'(uflow_o), 0);
    check("R1", ready === 1'b1, "ready in reset", 32'(ready), 1);
    wr_i = 0; rd_i = 0; mrun = 0; exp_nib = '0; exp_uf = 0;
    rst = 1'b0;
  endtask

  // Strobe on the cadence phases set in mask until n words are offered
  task automatic cadence(input int n, input logic [6:0] mask, input int seed,
                         input string req, input bit steady);
    int idx = 0, c = 0;
    while (idx < n) begin
      if (mask[c % 7]) begin
        if (steady && c > 0) check("R8", ready === 1'b1, "ready on cadence", 32'(ready), 1);
        step(1'b1, gen(seed + idx), req);
        idx++;
      end else begin
        step(1'b0, '0, req);
      end
      c++;
    end
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b0, '0, "R2");
    cadence(128, 7'b0110101, 0, "R3 R4", 1'b1);
    check("R8", uf_seen == 0, "underflow count on 4/7 cadence", 32'(uf_seen), 0);
    check("R8", stall_seen == 0, "stall count on 4/7 cadence", 32'(stall_seen), 0);
    for (int i = 0; i < 10; i++) step(1'b0, '0, "R6");
    check("R6", uf_seen > 0, "underflow seen after pause", 32'(uf_seen), 1);
    for (int i = 0; i < 60; i++) step(1'b1, gen(300 + i), "R7");
    check("R7", dropped > 0, "strobes dropped under flood", 32'(dropped), 1);
    cadence(128, 7'b0110101, 500, "R3 R4", 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, '0, "R6");
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b0, '0, "R2");
    cadence(64, 7'b0010101, 900, "R3 R4", 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, '0, "R6");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule